// File: doc/BRIEF.md
# PLL Counter Reconfiguration Sequencer

This block loads a new set of PLL counter settings through the PLL's serial scan chain. A single-cycle start request latches a 144-bit settings word. The sequencer then raises the scan enable, shifts the word out one bit per scan-clock cycle with the most significant bit first, and drops the enable. It issues a one-cycle update strobe and waits for the PLL's done signal to rise and then fall. The block runs entirely on the scan clock.

The sequencer keeps a copy of the last word that loaded successfully. When the loop-setting fields of the new word differ from that copy, it drives the PLL reset for a fixed number of cycles once the done signal has fallen. When any bit differs, it raises a flag that asks the surrounding logic to apply the phase offset again through the separate phase-shift path. A timeout guards both edges of the done handshake. A load that times out sets an error flag and leaves the stored copy unchanged.

Top module: `pll_scan_sequencer`

## Requirements
- R1: The chain is CHAIN_LEN (144) bits long. Each load presents exactly 144 bits on `scan_dat`, bit 143 first and bit 0 last, and the captured chain equals `cfg_word` as latched at start.
- R2: `scan_en` rises in the cycle after an accepted start and stays high for exactly CHAIN_LEN+1 cycles. The first rising edge with the enable high is a lead edge. Bit 143 is captured on the second rising edge with the enable high.
- R3: `scan_en` falls on the same edge where `cfg_update` rises, and the two are never high together.
- R4: `cfg_update` is high for exactly one cycle per load.
- R5: A load is complete only after `scan_done` has risen and then fallen. `busy` stays high for as long as `scan_done` is high, whatever the latency.
- R6: `pll_rst` is high for RST_CYCLES (4) cycles after the done fall if any bit in positions 143..108 differs from the last successfully loaded word (all zeros after reset). Otherwise `pll_rst` stays low. Bit 107 and the bits below it never trigger the reset.
- R7: `phase_redo` is set at successful completion if any bit of the new word differs from the last loaded word, and is cleared otherwise. An accepted start clears it.
- R8: `busy` is high from the cycle after an accepted start until the sequence ends, including any reset pulse. A start while busy is ignored, and its word does not reach the chain.
- R9: If `scan_done` does not rise, or does not fall, within TIMEOUT_CYC cycles, `err` is set, `busy` drops, no reset is pulsed and the stored word is not updated. The next accepted start clears `err`.
- R10: After reset, `scan_en`, `scan_dat`, `cfg_update`, `pll_rst`, `busy`, `phase_redo` and `err` are all low.
- R11: The sequence can be repeated any number of times, and each repetition follows R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle load request |
| cfg_word | input | 144 | New counter settings word |
| scan_done | input | 1 | PLL done handshake |
| scan_en | output | 1 | Scan-clock enable for the chain |
| scan_dat | output | 1 | Serial data into the chain |
| cfg_update | output | 1 | One-cycle strobe that transfers the chain into the counters |
| pll_rst | output | 1 | PLL reset pulse |
| busy | output | 1 | Sequence in progress |
| phase_redo | output | 1 | Phase offset must be applied again |
| err | output | 1 | Done handshake timed out |

## Verification
A shift counter off by one shows at once as an enable window one cycle short or long. It also corrupts the captured word, which the scoreboard sees at the done fall of that same load. A stale or wrongly updated copy of the previous word only shows at the end of the next load, as a missing or extra reset pulse or a wrong `phase_redo`. For that reason the loads are chained, so that each one depends on the result of the one before, including one after a timed-out load. A broken timeout shows as `err` or `busy` being wrong a timeout window after the update strobe.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_UPDATE,
        ST_WAIT_RISE,
        ST_WAIT_FALL,
        ST_PLL_RST
    } seq_state_e;
endpackage

// File: rtl/pll_scan_shifter.sv
module pll_scan_shifter #(
    parameter int LEN = 144
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] load_word,
    input  logic           shift,
    output logic           ser_out,
    output logic           last
);
    localparam int CW = $clog2(LEN);

    typedef struct packed {
        logic [LEN-1:0] sh;
        logic [CW-1:0]  cnt;
    } shf_t;

    shf_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.sh  = load_word;
            r_d.cnt = '0;
        end else if (shift) begin
            r_d.sh  = {r_q.sh[LEN-2:0], 1'b0};
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ser_out = r_q.sh[LEN-1];
    assign last    = (r_q.cnt == CW'(LEN-1));
endmodule

// File: rtl/pll_scan_fieldcmp.sv
module pll_scan_fieldcmp #(
    parameter int             LEN      = 144,
    parameter logic [LEN-1:0] RST_MASK = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic           commit,
    input  logic [LEN-1:0] word_in,
    output logic           need_rst,
    output logic           any_chg
);
    typedef struct packed {
        logic [LEN-1:0] cur;
        logic [LEN-1:0] prev;
    } cmp_t;

    cmp_t r_q, r_d;
    logic [LEN-1:0] diff;

    always_comb begin
        r_d = r_q;
        if (capture) r_d.cur  = word_in;
        if (commit)  r_d.prev = r_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign diff     = r_q.cur ^ r_q.prev;
    assign need_rst = |(diff & RST_MASK);
    assign any_chg  = |diff;
endmodule

// File: rtl/pll_scan_timer.sv
module pll_scan_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/pll_scan_sequencer.sv
module pll_scan_sequencer
    import pll_scan_pkg::*;
#(
    parameter int                   CHAIN_LEN      = 144,
    parameter logic [CHAIN_LEN-1:0] RST_FIELD_MASK = {{36{1'b1}}, {(CHAIN_LEN-36){1'b0}}},
    parameter int                   TIMEOUT_CYC    = 1024,
    parameter int                   RST_CYCLES     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CHAIN_LEN-1:0] cfg_word,
    input  logic                 scan_done,
    output logic                 scan_en,
    output logic                 scan_dat,
    output logic                 cfg_update,
    output logic                 pll_rst,
    output logic                 busy,
    output logic                 phase_redo,
    output logic                 err
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [RW-1:0] rcnt;
        logic          err;
        logic          redo;
    } ctl_t;

    ctl_t r_q, r_d;
    logic accept, commit;
    logic ser_out, last_bit;
    logic need_rst, any_chg;
    logic tmr_clear, tmr_run, tmr_exp;

    always_comb begin
        r_d    = r_q;
        accept = 1'b0;
        commit = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_LEAD;
                    r_d.err  = 1'b0;
                    r_d.redo = 1'b0;
                    accept   = 1'b1;
                end
            end
            ST_LEAD:  r_d.st = ST_SHIFT;
            ST_SHIFT: if (last_bit) r_d.st = ST_UPDATE;
            ST_UPDATE: r_d.st = ST_WAIT_RISE;
            ST_WAIT_RISE: begin
                if (scan_done) begin
                    r_d.st = ST_WAIT_FALL;
                end else if (tmr_exp) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_WAIT_FALL: begin
                if (!scan_done) begin
                    if (need_rst) begin
                        r_d.st   = ST_PLL_RST;
                        r_d.rcnt = '0;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.redo = any_chg;
                        commit   = 1'b1;
                    end
                end else if (tmr_exp) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_PLL_RST: begin
                if (r_q.rcnt == RW'(RST_CYCLES - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.redo = any_chg;
                    commit   = 1'b1;
                end else begin
                    r_d.rcnt = r_q.rcnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign tmr_clear = (r_q.st == ST_UPDATE) || ((r_q.st == ST_WAIT_RISE) && scan_done);
    assign tmr_run   = (r_q.st == ST_WAIT_RISE) || (r_q.st == ST_WAIT_FALL);

    pll_scan_shifter #(.LEN(CHAIN_LEN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_word(cfg_word),
        .shift    (r_q.st == ST_SHIFT),
        .ser_out  (ser_out),
        .last     (last_bit)
    );

    pll_scan_fieldcmp #(.LEN(CHAIN_LEN), .RST_MASK(RST_FIELD_MASK)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .commit  (commit),
        .word_in (cfg_word),
        .need_rst(need_rst),
        .any_chg (any_chg)
    );

    pll_scan_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .run    (tmr_run),
        .expired(tmr_exp)
    );

    assign scan_en    = (r_q.st == ST_LEAD) || (r_q.st == ST_SHIFT);
    assign scan_dat   = ser_out & scan_en;
    assign cfg_update = (r_q.st == ST_UPDATE);
    assign pll_rst    = (r_q.st == ST_PLL_RST);
    assign busy       = (r_q.st != ST_IDLE);
    assign phase_redo = r_q.redo;
    assign err        = r_q.err;
endmodule

// File: rtl/pll_scan_sequencer_chk.sv
module pll_scan_sequencer_chk #(
    parameter int CHAIN_LEN = 144
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic scan_en,
    input logic cfg_update,
    input logic pll_rst,
    input logic busy,
    input logic err
);
    localparam int EW = $clog2(CHAIN_LEN + 2);

    logic [EW-1:0] en_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       en_run_q <= '0;
        else if (scan_en) en_run_q <= en_run_q + 1'b1;
        else              en_run_q <= '0;
    end

    // R2: enable window is the lead cycle plus one cycle per bit
    a_r2_en_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (en_run_q == EW'(CHAIN_LEN + 1)));

    // R2: enable rises only right after a start accepted while idle
    a_r2_en_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en) |-> ($past(start) && !$past(busy)));

    // R3: update strobe directly follows the enable window
    a_r3_update_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_update) |-> $past(scan_en));

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |-> !scan_en);

    // R4: single-cycle update
    a_r4_update_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !cfg_update);

    // R6: reset pulse never overlaps shifting or update
    a_r6_rst_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> (!scan_en && !cfg_update));

    // R8: all sequence activity lies inside busy
    a_r8_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en || cfg_update || pll_rst) |-> busy);

    // R9: error flag only while idle
    a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

bind pll_scan_sequencer pll_scan_sequencer_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .scan_en   (scan_en),
    .cfg_update(cfg_update),
    .pll_rst   (pll_rst),
    .busy      (busy),
    .err       (err)
);

// File: tb/pll_scan_sequencer_bench.sv
`timescale 1ns/1ps
module pll_scan_sequencer_bench;
    localparam int LEN  = 144;
    localparam int TMO  = 200;
    localparam int RSTC = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [LEN-1:0] cfg_word = '0;
    logic           scan_done;
    logic           scan_en, scan_dat, cfg_update, pll_rst, busy, phase_redo, err;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    pll_scan_sequencer #(
        .CHAIN_LEN  (LEN),
        .TIMEOUT_CYC(TMO),
        .RST_CYCLES (RSTC)
    ) u_pll_scan_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_word  (cfg_word),
        .scan_done (scan_done),
        .scan_en   (scan_en),
        .scan_dat  (scan_dat),
        .cfg_update(cfg_update),
        .pll_rst   (pll_rst),
        .busy      (busy),
        .phase_redo(phase_redo),
        .err       (err)
    );

    // behavioural scan chain: mode 0 normal, 1 done never rises, 2 done never falls
    int             mdl_mode = 0;
    int             mdl_lat  = 5;
    bit             mdl_clr  = 1'b0;
    logic           primed;
    logic [LEN-1:0] chain;
    int             dcnt;
    int             cap_n;
    logic           first_bit;
    logic [LEN-1:0] got_q[$];
    logic [LEN-1:0] exp_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            chain     <= '0;
            scan_done <= 1'b0;
            dcnt      <= 0;
            cap_n     <= 0;
            first_bit <= 1'b0;
        end else begin
            if (scan_en) begin
                if (primed) begin
                    chain <= {chain[LEN-2:0], scan_dat};
                    if (cap_n == 0) first_bit <= scan_dat;
                    cap_n <= cap_n + 1;
                end else begin
                    cap_n <= 0;
                end
                primed <= 1'b1;
            end else begin
                primed <= 1'b0;
            end
            if (mdl_clr) begin
                scan_done <= 1'b0;
            end else if (cfg_update && mdl_mode != 1) begin
                scan_done <= 1'b1;
                dcnt      <= mdl_lat;
            end else if (scan_done && mdl_mode != 2) begin
                if (dcnt == 0) begin
                    scan_done <= 1'b0;
                    got_q.push_back(chain);
                end else begin
                    dcnt <= dcnt - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LEN-1:0] act, input logic [LEN-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor: words captured at done fall vs words expected
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [LEN-1:0] g;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected load", g, '0);
                end else begin
                    logic [LEN-1:0] e;
                    e = exp_q.pop_front();
                    chk(g == e, "R1", "chain contents", g, e);
                end
            end
        end
    end

    task automatic run_seq(input logic [LEN-1:0] word, input int mode, input int lat,
                           input bit exp_rst, input bit exp_redo, input bit exp_err,
                           input bit poke, input string tag);
        int en_len = 0, upd_len = 0, rst_len = 0, cyc = 0, bad_done = 0;
        bit saw_done = 1'b0;
        mdl_mode = mode;
        mdl_lat  = lat;
        if (mode == 0) exp_q.push_back(word);
        @(negedge clk);
        start    = 1'b1;
        cfg_word = word;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", {tag, " busy after start"}, LEN'(busy), LEN'(1));
        chk(scan_en == 1'b1, "R2", {tag, " enable after start"}, LEN'(scan_en), LEN'(1));
        chk(phase_redo == 1'b0 && err == 1'b0, "R7", {tag, " flags cleared by start"},
            LEN'({phase_redo, err}), LEN'(0));
        while (busy) begin
            en_len  += int'(scan_en);
            upd_len += int'(cfg_update);
            rst_len += int'(pll_rst);
            if (scan_done) saw_done = 1'b1;
            if (pll_rst && scan_done) bad_done++;
            cyc++;
            if (poke && cyc == 20) begin
                start    = 1'b1;
                cfg_word = ~word;
            end else begin
                start    = 1'b0;
                cfg_word = word;
            end
            @(negedge clk);
            if (poke && cyc == 20) begin
                start = 1'b0;
                chk(busy == 1'b1, "R8", {tag, " busy after ignored start"}, LEN'(busy), LEN'(1));
            end
            if (cyc > 2000) break;
        end
        start = 1'b0;
        if (mode == 0 && scan_done) bad_done++;
        chk(en_len == LEN + 1, "R2", {tag, " enable width"}, LEN'(en_len), LEN'(LEN + 1));
        chk(upd_len == 1, "R4", {tag, " update width"}, LEN'(upd_len), LEN'(1));
        chk(rst_len == (exp_rst ? RSTC : 0), "R6", {tag, " reset pulse"},
            LEN'(rst_len), LEN'(exp_rst ? RSTC : 0));
        chk(phase_redo == exp_redo, "R7", {tag, " phase redo"}, LEN'(phase_redo), LEN'(exp_redo));
        chk(err == exp_err, "R9", {tag, " error flag"}, LEN'(err), LEN'(exp_err));
        chk(cap_n == LEN, "R1", {tag, " bits captured"}, LEN'(cap_n), LEN'(LEN));
        chk(first_bit == word[LEN-1], "R1", {tag, " first bit is MSB"},
            LEN'(first_bit), LEN'(word[LEN-1]));
        if (mode == 0) begin
            chk(saw_done && bad_done == 0, "R5", {tag, " completes on done fall"},
                LEN'(bad_done), LEN'(0));
        end
        @(negedge clk);
        chk(exp_q.size() == 0, "R1", {tag, " scoreboard drained"}, LEN'(exp_q.size()), LEN'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] wa, wb, wc, wd, we;
        wa = {4{36'h9A5C31E70}};
        wb = wa ^ LEN'(1);
        wc = wb ^ (LEN'(1) << 120);
        wd = wc ^ (LEN'(1) << 143);
        we = wd ^ (LEN'(1) << 107);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({scan_en, scan_dat, cfg_update, pll_rst, busy, phase_redo, err} == 7'b0,
            "R10", "outputs after reset",
            LEN'({scan_en, scan_dat, cfg_update, pll_rst, busy, phase_redo, err}), LEN'(0));

        run_seq(wa, 0, 5,  1'b1, 1'b1, 1'b0, 1'b0, "first load");          // R6 vs zero copy
        run_seq(wa, 0, 30, 1'b0, 1'b0, 1'b0, 1'b0, "repeat long latency"); // R5 R11
        run_seq(wb, 0, 3,  1'b0, 1'b1, 1'b0, 1'b1, "low bit change");      // R8 ignored start
        run_seq(wc, 0, 0,  1'b1, 1'b1, 1'b0, 1'b0, "bit 120 change");      // R6
        run_seq(wd, 1, 0,  1'b0, 1'b0, 1'b1, 1'b0, "no done rise");        // R9
        run_seq(wd, 0, 7,  1'b1, 1'b1, 1'b0, 1'b0, "after rise timeout");  // R9 copy kept
        run_seq(wd, 2, 0,  1'b0, 1'b0, 1'b1, 1'b0, "no done fall");        // R9
        mdl_clr = 1'b1;
        @(negedge clk);
        mdl_clr = 1'b0;
        run_seq(we, 0, 2,  1'b0, 1'b1, 1'b0, 1'b0, "bit 107 change");      // R6 boundary
        run_seq(we ^ (LEN'(1) << 108), 0, 4, 1'b1, 1'b1, 1'b0, 1'b0, "bit 108 change");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule